// File: doc/BRIEF.md
# CPU and Video Shared-Memory Wait Arbiter

This block sits between an 8-bit CPU, a video fetch path and a single shared DRAM. All of them are clocked from one 16 MHz master clock. The block divides that clock into a 4 MHz CPU clock enable. It groups four CPU T-states into a fixed 1 µs frame, and each T-state has four master-clock sub-phases. One T-state of every frame is set aside for a video read. In that slot the address mux hands the DRAM to the display refresh address, the CPU data bus is cut off, and the byte that is read is latched for the pixel path.

The video path always wins. The block does not let a CPU bus cycle finish mid-frame. It pulls the active-low WAIT line down while a bus request is open and lets it go only in the last T-state of the frame. As a result, every CPU bus transfer ends on a 1 µs boundary and the video slot always falls inside a stall. Short 3-T-state cycles are stretched to 4 T-states. Cycles that start late in a frame run on to the end of the following frame. This stretching applies whether or not the display is active. When the display-enable flag is low, no video read happens.

Top module: `shared_mem_arbiter`

## Requirements
- R1: `cpu_ce` is high for exactly one master clock in every four, always in the last sub-phase (index 3) of a T-state.
- R2: `wait_n` changes only on the master edge that closes sub-phase 1 of a T-state, which is the falling edge of the CPU clock.
- R3: A CPU bus cycle needs N T-states (N of 3 or 4) and starts at T-state index s of a frame. It ends after the smallest count t ≥ N for which (s + t − 1) mod 4 = 3, so it always ends in T-state index 3.
- R4: While `de` is low, `mux_sel` stays low and `video_byte` keeps its value, but R3 stretching still applies.
- R5: In the video slot (T-state index 1 of a frame, with `de` high on the edge that enters the slot), `mux_sel` is high, `bus_iso_n` is low and `mem_addr` equals `vid_addr`.
- R6: At the end of each video slot, `video_byte` takes `mem_rdata` for the video address. It changes only on the clock that closes a slot.
- R7: `wait_n` is high at every `cpu_ce` that ends T-state index 3.
- R8: With no bus request open, `wait_n` returns high within one T-state and stays high.
- R9: A bus request is either (`mreq_n` or `iorq_n` low) together with (`rd_n` or `wr_n` low), or `m1_n` and `iorq_n` both low (interrupt acknowledge). Opcode fetch, memory write, I/O read and interrupt acknowledge are all stretched.
- R10: Outside the video slot, `mem_addr` follows `cpu_addr` one master clock later.
- R11: During synchronous reset, `cpu_ce`=0, `wait_n`=1, `mux_sel`=0, `bus_iso_n`=1, `mem_addr`=0 and `video_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| m1_n | input | 1 | CPU opcode-fetch / acknowledge marker, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| cpu_addr | input | ADDR_W | CPU address |
| de | input | 1 | Display enable from the display timing controller |
| vid_addr | input | ADDR_W | Refresh address from the display timing controller |
| mem_rdata | input | DATA_W | DRAM read data |
| cpu_ce | output | 1 | CPU clock enable (4 MHz) |
| wait_n | output | 1 | CPU wait request, active low |
| mux_sel | output | 1 | DRAM address mux select, high selects video |
| bus_iso_n | output | 1 | CPU data-bus isolation strobe, active low |
| mem_addr | output | ADDR_W | Muxed DRAM address |
| video_byte | output | DATA_W | Latched video byte |

## Verification
The bench builds the block with its defaults: 16-bit addresses, 8-bit data, four sub-phases and four T-states per frame, the video slot at T-state 1 and WAIT updates in sub-phase 1. With these values one frame is 16 master clocks. That is short enough to cover every start position within a frame for 3- and 4-T-state cycles, including a 4-T-state cycle that starts in the last T-state and must run 5 T-states. It also covers frames with the display on and off, and a run of video slots at changing refresh addresses that are checked against a computed memory image.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Kinds of CPU bus activity that hold the bus and must be frame aligned.
  function automatic logic cpu_bus_req(input logic m1_n, input logic mreq_n,
                                       input logic iorq_n, input logic rd_n,
                                       input logic wr_n);
    return ((!mreq_n || !iorq_n) && (!rd_n || !wr_n)) || (!m1_n && !iorq_n);
  endfunction

endpackage

// File: rtl/arb_phase.sv
module arb_phase #(
  parameter int SUB_W = 2,
  parameter int TS_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [SUB_W-1:0] sub,
  output logic [TS_W-1:0]  ts,
  output logic [TS_W-1:0]  ts_nxt,
  output logic             cpu_ce
);
  localparam int CW = SUB_W + TS_W;
  localparam logic [SUB_W-1:0] LAST_SUB = {SUB_W{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          ce_q;

  assign cnt_nxt = cnt_q + {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ce_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      ce_q  <= (cnt_nxt[SUB_W-1:0] == LAST_SUB);
    end
  end

  assign sub    = cnt_q[SUB_W-1:0];
  assign ts     = cnt_q[CW-1:SUB_W];
  assign ts_nxt = cnt_nxt[CW-1:SUB_W];
  assign cpu_ce = ce_q;
endmodule

// File: rtl/arb_wait.sv
module arb_wait #(
  parameter int SUB_W   = 2,
  parameter int TS_W    = 2,
  parameter int WAIT_PH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [SUB_W-1:0] sub,
  input  logic [TS_W-1:0]  ts,
  output logic             wait_n
);
  localparam logic [SUB_W-1:0] UPD_PH  = SUB_W'(WAIT_PH);
  localparam logic [TS_W-1:0]  LAST_TS = {TS_W{1'b1}};

  logic wait_n_q;

  // Updated only on the CPU-clock falling edge; held low until the frame's last T-state.
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_n_q <= 1'b1;
    end else if (sub == UPD_PH) begin
      wait_n_q <= !(req && (ts != LAST_TS));
    end
  end

  assign wait_n = wait_n_q;
endmodule

// File: rtl/arb_vfetch.sv
module arb_vfetch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SUB_W  = 2,
  parameter int TS_W   = 2,
  parameter int VSLOT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [SUB_W-1:0]  sub,
  input  logic [TS_W-1:0]   ts_nxt,
  output logic              mux_sel,
  output logic              bus_iso_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] video_byte
);
  localparam logic [TS_W-1:0]  VS       = TS_W'(VSLOT);
  localparam logic [SUB_W-1:0] LAST_SUB = {SUB_W{1'b1}};

  logic              sel_nxt;
  logic              sel_q;
  logic              iso_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] byte_q;

  assign sel_nxt = de && (ts_nxt == VS);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      iso_n_q <= 1'b1;
      addr_q  <= '0;
      byte_q  <= '0;
    end else begin
      sel_q   <= sel_nxt;
      iso_n_q <= !sel_nxt;
      addr_q  <= sel_nxt ? vid_addr : cpu_addr;
      if (sel_q && (sub == LAST_SUB)) begin
        byte_q <= mem_rdata;
      end
    end
  end

  assign mux_sel    = sel_q;
  assign bus_iso_n  = iso_n_q;
  assign mem_addr   = addr_q;
  assign video_byte = byte_q;
endmodule

// File: rtl/shared_mem_arbiter.sv
module shared_mem_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SUB_W   = 2,
  parameter int TS_W    = 2,
  parameter int VSLOT   = 1,
  parameter int WAIT_PH = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m1_n,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              de,
  input  logic [ADDR_W-1:0] vid_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cpu_ce,
  output logic              wait_n,
  output logic              mux_sel,
  output logic              bus_iso_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] video_byte
);
  logic [SUB_W-1:0] sub_w;
  logic [TS_W-1:0]  ts_w;
  logic [TS_W-1:0]  ts_nxt_w;
  logic             req_w;

  assign req_w = cpu_bus_req(m1_n, mreq_n, iorq_n, rd_n, wr_n);

  arb_phase #(.SUB_W(SUB_W), .TS_W(TS_W)) u_phase (
    .clk(clk), .rst(rst), .sub(sub_w), .ts(ts_w), .ts_nxt(ts_nxt_w), .cpu_ce(cpu_ce)
  );

  arb_wait #(.SUB_W(SUB_W), .TS_W(TS_W), .WAIT_PH(WAIT_PH)) u_wait (
    .clk(clk), .rst(rst), .req(req_w), .sub(sub_w), .ts(ts_w), .wait_n(wait_n)
  );

  arb_vfetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUB_W(SUB_W), .TS_W(TS_W),
               .VSLOT(VSLOT)) u_vfetch (
    .clk(clk), .rst(rst), .de(de), .vid_addr(vid_addr), .cpu_addr(cpu_addr),
    .mem_rdata(mem_rdata), .sub(sub_w), .ts_nxt(ts_nxt_w), .mux_sel(mux_sel),
    .bus_iso_n(bus_iso_n), .mem_addr(mem_addr), .video_byte(video_byte)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SUB_W   = 2,
  parameter int TS_W    = 2,
  parameter int WAIT_PH = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              m1_n,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              de,
  input logic              cpu_ce,
  input logic              wait_n,
  input logic              mux_sel,
  input logic              bus_iso_n,
  input logic [DATA_W-1:0] video_byte,
  input logic [SUB_W-1:0]  sub,
  input logic [TS_W-1:0]   ts
);
  localparam logic [SUB_W-1:0] LAST_SUB = {SUB_W{1'b1}};
  localparam logic [SUB_W-1:0] UPD_PH   = SUB_W'(WAIT_PH);
  localparam logic [TS_W-1:0]  LAST_TS  = {TS_W{1'b1}};

  logic req;
  assign req = cpu_bus_req(m1_n, mreq_n, iorq_n, rd_n, wr_n);

  assert_ce_last_sub_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |-> (sub == LAST_SUB));
  assert_ce_single_R1: assert property (@(posedge clk) disable iff (rst)
    cpu_ce |=> !cpu_ce);
  assert_wait_on_fall_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(wait_n) |-> ($past(sub) == UPD_PH));
  assert_no_read_without_de_R4: assert property (@(posedge clk) disable iff (rst)
    mux_sel |-> $past(de));
  assert_iso_in_slot_R5: assert property (@(posedge clk) disable iff (rst)
    mux_sel |-> !bus_iso_n);
  assert_latch_after_slot_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(video_byte) |-> $past(mux_sel));
  assert_release_last_t_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && (ts == LAST_TS)) |-> wait_n);
  assert_wait_needs_req_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_n) |-> $past(req));
endmodule

bind shared_mem_arbiter arb_checker #(
  .DATA_W(DATA_W), .SUB_W(SUB_W), .TS_W(TS_W), .WAIT_PH(WAIT_PH)
) u_chk (
  .clk(clk), .rst(rst), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
  .rd_n(rd_n), .wr_n(wr_n), .de(de), .cpu_ce(cpu_ce), .wait_n(wait_n),
  .mux_sel(mux_sel), .bus_iso_n(bus_iso_n), .video_byte(video_byte),
  .sub(sub_w), .ts(ts_w)
);

// File: tb/shared_mem_arbiter_bench.sv
module shared_mem_arbiter_bench;
  localparam int CLK_PERIOD = 62;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m1_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic        de = 1'b0;
  logic [15:0] vid_addr = 16'h4000;
  logic [7:0]  mem_rdata;
  logic        cpu_ce, wait_n, mux_sel, bus_iso_n;
  logic [15:0] mem_addr;
  logic [7:0]  video_byte;

  int   checks = 0;
  int   errors = 0;
  int   ce_cnt = 0;
  int   slots  = 0;
  bit   feed_en = 1'b0;
  bit   finished = 1'b0;
  logic [7:0] vq[$];
  int         cq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = memf(mem_addr);

  shared_mem_arbiter u_shared_mem_arbiter (
    .clk(clk), .rst(rst), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .cpu_addr(cpu_addr), .de(de), .vid_addr(vid_addr),
    .mem_rdata(mem_rdata), .cpu_ce(cpu_ce), .wait_n(wait_n), .mux_sel(mux_sel),
    .bus_iso_n(bus_iso_n), .mem_addr(mem_addr), .video_byte(video_byte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) if (!rst && cpu_ce) ce_cnt <= ce_cnt + 1;

  // Frame feeder: display enable and refresh address change only at frame boundaries.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cpu_ce && (ce_cnt % 4 == 3)) begin
        de = feed_en;
        if (feed_en) begin
          vid_addr = vid_addr + 16'h0137;
          vq.push_back(memf(vid_addr));
        end
      end
    end
  end

  // Monitor: video slots and wait-edge timing.
  logic       prev_mux = 1'b0;
  logic       prev_wait = 1'b1;
  logic [2:0] ceh = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mux_sel) begin
        chk(mem_addr == vid_addr, "R5 addr", int'(mem_addr), int'(vid_addr));
        chk(!bus_iso_n, "R5 iso", int'(bus_iso_n), 0);
      end
      if (mux_sel && !prev_mux) slots++;
      if (prev_mux && !mux_sel) begin
        if (vq.size() == 0) chk(1'b0, "R6 unexpected slot", 1, 0);
        else begin
          logic [7:0] e;
          e = vq.pop_front();
          chk(video_byte == e, "R6 latch", int'(video_byte), int'(e));
        end
      end
      if (wait_n != prev_wait)
        chk(ceh[2], "R2 wait edge phase", int'(ceh), 4);
    end
    prev_mux  <= mux_sel;
    prev_wait <= wait_n;
    ceh       <= {ceh[1:0], cpu_ce};
  end

  // Drive one CPU bus cycle of n T-states starting at T-state s of a frame.
  task automatic run_cycle(input int s, input int n, input int kind,
                           input logic [15:0] a, input string tag);
    int t;
    int ex;
    bit done;
    do @(negedge clk); while (!(cpu_ce && (ce_cnt % 4 == (s + 3) % 4)));
    cpu_addr = a;
    case (kind)
      0: begin m1_n = 1'b0; mreq_n = 1'b0; rd_n = 1'b0; end
      1: begin mreq_n = 1'b0; wr_n = 1'b0; end
      2: begin iorq_n = 1'b0; rd_n = 1'b0; end
      default: begin m1_n = 1'b0; iorq_n = 1'b0; end
    endcase
    ex = n;
    while ((s + ex - 1) % 4 != 3) ex++;
    cq.push_back(ex);
    t = 0;
    done = 1'b0;
    while (!done) begin
      @(negedge clk);
      if (cpu_ce) begin
        t++;
        if (t >= n && wait_n) done = 1'b1;
        if (t > 12) begin done = 1'b1; end
      end
    end
    ex = cq.pop_front();
    chk(t == ex, {tag, " R3 length"}, t, ex);
    chk(ce_cnt % 4 == 3, {tag, " R3 end T-state"}, ce_cnt % 4, 3);
    chk(wait_n, {tag, " R7 release"}, int'(wait_n), 1);
    chk(mem_addr == a, {tag, " R10 cpu addr"}, int'(mem_addr), int'(a));
    @(negedge clk);
    m1_n = 1'b1; mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    int s0;
    logic [7:0] b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(!cpu_ce, "R11 cpu_ce", int'(cpu_ce), 0);
    chk(wait_n, "R11 wait_n", int'(wait_n), 1);
    chk(!mux_sel && bus_iso_n, "R11 mux/iso", int'({mux_sel, bus_iso_n}), 1);
    chk(mem_addr == 0 && video_byte == 0, "R11 addr/byte", int'(video_byte), 0);
    rst = 1'b0;
    // R1 clock enable rate
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (cpu_ce) cnt++;
    end
    chk(cnt == 16, "R1 ce count", cnt, 16);
    // R5/R6 video slots with display on, CPU idle
    @(posedge clk); feed_en = 1'b1;
    repeat (6 * 16) @(negedge clk);
    @(posedge clk); feed_en = 1'b0;
    repeat (3 * 16) @(negedge clk);
    chk(slots >= 6, "R5 slot count", slots, 6);
    chk(wait_n, "R8 idle wait", int'(wait_n), 1);
    // R4: display off, CPU cycles still aligned (R3, R9)
    s0 = slots;
    b0 = video_byte;
    run_cycle(0, 4, 0, 16'h1234, "fetch4@0");
    run_cycle(0, 3, 1, 16'h2345, "write3@0");
    run_cycle(1, 3, 2, 16'h3456, "io3@1");
    run_cycle(1, 4, 3, 16'h4567, "R9 intack4@1");
    run_cycle(2, 3, 0, 16'h5678, "fetch3@2");
    run_cycle(3, 4, 2, 16'h6789, "io4@3");
    chk(slots == s0, "R4 no slot", slots, s0);
    chk(video_byte == b0, "R4 byte held", int'(video_byte), int'(b0));
    // Display on during CPU activity
    @(posedge clk); feed_en = 1'b1;
    run_cycle(0, 3, 0, 16'h789A, "fetch3@0 de");
    run_cycle(1, 4, 1, 16'h89AB, "write4@1 de");
    run_cycle(2, 4, 0, 16'h9ABC, "fetch4@2 de");
    @(posedge clk); feed_en = 1'b0;
    repeat (3 * 16) @(negedge clk);
    chk(vq.size() == 0, "R6 all slots seen", vq.size(), 0);
    chk(wait_n, "R8 idle after cycles", int'(wait_n), 1);
    finish_run();
  end
endmodule